// File: doc/BRIEF.md
# Hybrid Direction Predictor with Per-Branch Chooser

This block guesses whether a conditional branch will be taken, using two component predictors and a third table that picks between them for each branch. The first component is a table of 2-bit saturating counters addressed only by the branch address. The second is a table of the same kind addressed by the branch address XOR-folded with a register of recent resolved outcomes. The chooser is a third table of 2-bit counters, also addressed by branch address, that decides which component's guess is used.

At fetch, the front end presents a branch address and receives, in the same cycle, the final guess, both component guesses, the chooser's pick and the two table indices. The pipeline carries the indices and component guesses with the branch. When the branch resolves, it hands them back together with the real outcome. Both components learn from every resolved branch. The chooser learns only when the two components had disagreed. All tables start weakly taken, and every chooser entry starts leaning toward the address-only component, because that component needs less time to learn.

Top module: `hybrid_predictor`

## Requirements
- R1: After reset every address-only and history counter holds 2 (weakly taken), every chooser counter holds 1, and the outcome history register holds 0. A fetch at any address then gives predBim=1, predHist=1, predUseHist=0 and predTaken=1.
- R2: The address-only index and the chooser index are fetchPc[IDX_W+1:2], returned on fetchBimIdx.
- R3: The history index is fetchPc[IDX_W+1:2] XOR the history register. Each resolve shifts the history register left by one and puts resTaken into bit 0. The index is returned on fetchHistIdx.
- R4: All counters are 2-bit and saturate at 0 and 3. A component guesses taken when its counter's MSB is 1. On every resolve, both components' counters count up if the branch was taken and down if it was not, whichever component was chosen.
- R5: A chooser counter with MSB 1 selects the history component. predTaken equals the selected component's guess, and predUseHist is that MSB.
- R6: The chooser entry changes only when resBimPred differs from resHistPred. It counts up if the history guess matched resTaken and down if the address-only guess did, saturating at 0 and 3.
- R7: Training uses the indices and component guesses returned at resolve, not the current table contents.
- R8: While resValid is low, no counter and no history bit changes, whatever the other resolve inputs carry.
- R9: When a fetch and a resolve address the same entry in the same cycle, the fetch sees the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | PC_W | Branch address being fetched |
| predTaken | output | 1 | Final direction guess |
| predBim | output | 1 | Address-only component guess |
| predHist | output | 1 | History component guess |
| predUseHist | output | 1 | Chooser picked the history component |
| fetchBimIdx | output | IDX_W | Address-only and chooser index |
| fetchHistIdx | output | IDX_W | History component index |
| resValid | input | 1 | A branch resolves this cycle |
| resTaken | input | 1 | Real outcome of the resolving branch |
| resBimIdx | input | IDX_W | Address-only index captured at fetch |
| resHistIdx | input | IDX_W | History index captured at fetch |
| resBimPred | input | 1 | Address-only guess captured at fetch |
| resHistPred | input | 1 | History guess captured at fetch |

## Verification
The bench drives counters into both saturation limits. A wrapping counter would turn a strongly-taken entry into a not-taken guess, or the reverse. It resolves branches whose returned guesses disagree while the live table entries agree, so a chooser that re-read the tables would stay put instead of moving. It sends resolves where the guesses agree and checks the chooser is unchanged, and it holds resValid low with busy side inputs, which would expose any leaky write enable. It also fetches and resolves the same entry in one cycle and expects the old value, and it follows the history register through the returned history index.

// File: rtl/hyb_pkg.sv
`timescale 1ns/1ps
package hyb_pkg;
  // Training strobes from the control to the datapath
  typedef struct packed {
    logic bimInc;
    logic bimDec;
    logic gshInc;
    logic gshDec;
    logic selInc;
    logic selDec;
    logic ghrShift;
    logic ghrBit;
  } trainStrb_t;

  localparam logic [1:0] CNT_INIT = 2'd2;
  localparam logic [1:0] SEL_INIT = 2'd1;
endpackage

// File: rtl/hyb_ctrl.sv
`timescale 1ns/1ps
module hyb_ctrl
  import hyb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       resValid,
  input  logic       resTaken,
  input  logic       resBimPred,
  input  logic       resGshPred,
  output trainStrb_t strb
);
  logic disagree;

  always_comb begin
    disagree      = resBimPred ^ resGshPred;
    strb.bimInc   = resValid & resTaken;
    strb.bimDec   = resValid & ~resTaken;
    strb.gshInc   = resValid & resTaken;
    strb.gshDec   = resValid & ~resTaken;
    strb.selInc   = resValid & disagree & (resGshPred == resTaken);
    strb.selDec   = resValid & disagree & (resBimPred == resTaken);
    strb.ghrShift = resValid;
    strb.ghrBit   = resTaken;
  end

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selInc, strb.selDec})); // R6
  AST_TRAIN_EVERY: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($countones({strb.gshInc, strb.gshDec, strb.bimInc, strb.bimDec}) == 2)); // R4
endmodule

// File: rtl/hyb_datapath.sv
`timescale 1ns/1ps
module hyb_datapath
  import hyb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] fetchIdx,
  input  trainStrb_t       strb,
  input  logic [IDX_W-1:0] resBimIdx,
  input  logic [IDX_W-1:0] resGshIdx,
  output logic [IDX_W-1:0] bimIdx,
  output logic [IDX_W-1:0] gshIdx,
  output logic             bimPred,
  output logic             gshPred,
  output logic             useHist,
  output logic             finalPred
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0]       bimTab [ENTRIES];
  logic [1:0]       gshTab [ENTRIES];
  logic [1:0]       selTab [ENTRIES];
  logic [IDX_W-1:0] ghr;
  logic [1:0]       bimCur, gshCur, selCur;

  function automatic logic [1:0] satStep(input logic [1:0] v, input logic up, input logic dn);
    if (up && v != 2'd3) return v + 2'd1;
    if (dn && v != 2'd0) return v - 2'd1;
    return v;
  endfunction

  // Fetch side: read before any same-cycle write lands
  always_comb begin
    bimIdx    = fetchIdx;
    gshIdx    = fetchIdx ^ ghr;
    bimPred   = bimTab[bimIdx][1];
    gshPred   = gshTab[gshIdx][1];
    useHist   = selTab[bimIdx][1];
    finalPred = useHist ? gshPred : bimPred;
    bimCur    = bimTab[resBimIdx];
    gshCur    = gshTab[resGshIdx];
    selCur    = selTab[resBimIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        bimTab[e] <= CNT_INIT;
        gshTab[e] <= CNT_INIT;
        selTab[e] <= SEL_INIT;
      end
    end else begin
      bimTab[resBimIdx] <= satStep(bimCur, strb.bimInc, strb.bimDec);
      selTab[resBimIdx] <= satStep(selCur, strb.selInc, strb.selDec);
      gshTab[resGshIdx] <= satStep(gshCur, strb.gshInc, strb.gshDec);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ghr <= '0;
    else if (strb.ghrShift) ghr <= {ghr[IDX_W-2:0], strb.ghrBit};
  end

  AST_BIM_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bimInc && bimCur != 2'd3) |=> (bimTab[$past(resBimIdx)] == $past(bimCur) + 2'd1)); // R4
  AST_BIM_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bimDec && bimCur == 2'd0) |=> (bimTab[$past(resBimIdx)] == 2'd0)); // R4
  AST_GSH_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.gshInc && gshCur == 2'd3) |=> (gshTab[$past(resGshIdx)] == 2'd3)); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.selInc && !strb.selDec) |=> (selTab[$past(resBimIdx)] == $past(selCur))); // R6
  AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strb.ghrShift |=> (ghr[0] == $past(strb.ghrBit))); // R3
  AST_GHR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ghrShift |=> $stable(ghr)); // R8
endmodule

// File: rtl/hybrid_predictor.sv
`timescale 1ns/1ps
module hybrid_predictor
  import hyb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  output logic             predTaken,
  output logic             predBim,
  output logic             predHist,
  output logic             predUseHist,
  output logic [IDX_W-1:0] fetchBimIdx,
  output logic [IDX_W-1:0] fetchHistIdx,
  input  logic             resValid,
  input  logic             resTaken,
  input  logic [IDX_W-1:0] resBimIdx,
  input  logic [IDX_W-1:0] resHistIdx,
  input  logic             resBimPred,
  input  logic             resHistPred
);
  trainStrb_t strb;
  logic       unusedPcBits;

  assign unusedPcBits = ^{fetchPc[PC_W-1:IDX_W+2], fetchPc[1:0]};

  hyb_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resValid   (resValid),
    .resTaken   (resTaken),
    .resBimPred (resBimPred),
    .resGshPred (resHistPred),
    .strb       (strb)
  );

  hyb_datapath #(.IDX_W(IDX_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fetchIdx  (fetchPc[IDX_W+1:2]),
    .strb      (strb),
    .resBimIdx (resBimIdx),
    .resGshIdx (resHistIdx),
    .bimIdx    (fetchBimIdx),
    .gshIdx    (fetchHistIdx),
    .bimPred   (predBim),
    .gshPred   (predHist),
    .useHist   (predUseHist),
    .finalPred (predTaken)
  );
endmodule

// File: tb/test_hybrid_predictor.sv
`timescale 1ns/1ps
module test_hybrid_predictor;
  localparam int PC_W = 32;
  localparam int IW   = 6;
  localparam int N    = 1 << IW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic predTaken, predBim, predHist, predUseHist;
  logic [IW-1:0] fetchBimIdx, fetchHistIdx;
  logic resValid = 1'b0, resTaken = 1'b0, resBimPred = 1'b0, resHistPred = 1'b0;
  logic [IW-1:0] resBimIdx = '0, resHistIdx = '0;

  int nChecks = 0;
  int nFail = 0;

  logic [1:0] mBim [N];
  logic [1:0] mGsh [N];
  logic [1:0] mSel [N];
  logic [IW-1:0] mGhr;

  always #10 clk = ~clk;

  hybrid_predictor #(.PC_W(PC_W), .IDX_W(IW)) i_hybrid_predictor (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predTaken(predTaken),
    .predBim(predBim), .predHist(predHist), .predUseHist(predUseHist),
    .fetchBimIdx(fetchBimIdx), .fetchHistIdx(fetchHistIdx),
    .resValid(resValid), .resTaken(resTaken), .resBimIdx(resBimIdx),
    .resHistIdx(resHistIdx), .resBimPred(resBimPred), .resHistPred(resHistPred)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] sat(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  task automatic modelTrain(input logic [IW-1:0] b, input logic [IW-1:0] g,
                            input logic bp, input logic gp, input logic t);
    mBim[b] = sat(mBim[b], t);
    mGsh[g] = sat(mGsh[g], t);
    if (bp != gp) mSel[b] = sat(mSel[b], gp == t);
    mGhr = {mGhr[IW-2:0], t};
  endtask

  // Present an address and compare every fetch output with the model
  task automatic fetchCheck(input string req, input logic [IW-1:0] idx);
    logic [IW-1:0] gi;
    logic useH;
    fetchPc = {{(PC_W-IW-2){1'b1}}, idx, 2'b01};
    #1;
    gi = idx ^ mGhr;
    useH = mSel[idx][1];
    chk(req, "bimIdx", 32'(fetchBimIdx), 32'(idx));
    chk(req, "histIdx", 32'(fetchHistIdx), 32'(gi));
    chk(req, "predBim", 32'(predBim), 32'(mBim[idx][1]));
    chk(req, "predHist", 32'(predHist), 32'(mGsh[gi][1]));
    chk(req, "useHist", 32'(predUseHist), 32'(useH));
    chk(req, "predTaken", 32'(predTaken), 32'(useH ? mGsh[gi][1] : mBim[idx][1]));
  endtask

  task automatic resolve(input logic [IW-1:0] b, input logic [IW-1:0] g,
                         input logic bp, input logic gp, input logic t);
    @(negedge clk);
    resValid = 1'b1; resBimIdx = b; resHistIdx = g;
    resBimPred = bp; resHistPred = gp; resTaken = t;
    @(posedge clk);
    modelTrain(b, g, bp, gp, t);
    @(negedge clk);
    resValid = 1'b0;
  endtask

  task automatic testReset();
    fetchCheck("R1", 6'd16);
    chk("R1", "predTaken literal", 32'(predTaken), 32'd1);
    chk("R1", "useHist literal", 32'(predUseHist), 32'd0);
    chk("R2", "bimIdx literal", 32'(fetchBimIdx), 32'd16);
    chk("R3", "histIdx with empty history", 32'(fetchHistIdx), 32'd16);
  endtask

  task automatic testSaturation();
    resolve(6'd5, 6'd40, 1'b1, 1'b1, 1'b0);
    fetchCheck("R4", 6'd5);
    chk("R4", "one not-taken drops guess", 32'(predBim), 32'd0);
    fetchCheck("R4", 6'd40 ^ mGhr);
    chk("R4", "history table trained too", 32'(predHist), 32'd0);
    repeat (3) resolve(6'd5, 6'd40, 1'b1, 1'b1, 1'b1);
    resolve(6'd5, 6'd40, 1'b1, 1'b1, 1'b0);
    fetchCheck("R4", 6'd5);
    chk("R4", "upper saturation keeps taken", 32'(predBim), 32'd1);
    repeat (3) resolve(6'd5, 6'd40, 1'b0, 1'b0, 1'b0);
    resolve(6'd5, 6'd40, 1'b0, 1'b0, 1'b1);
    fetchCheck("R4", 6'd5);
    chk("R4", "lower saturation keeps not-taken", 32'(predBim), 32'd0);
    fetchCheck("R3", 6'd40 ^ mGhr);
    chk("R3", "history index follows outcomes", 32'(fetchHistIdx), 32'd40);
  endtask

  task automatic testChooser();
    // Live entries agree, returned guesses disagree: chooser must move (R7)
    resolve(6'd10, 6'd50, 1'b1, 1'b0, 1'b0);
    fetchCheck("R6", 6'd10);
    chk("R7", "chooser moved on returned guesses", 32'(predUseHist), 32'd1);
    chk("R5", "final follows history guess", 32'(predTaken), 32'(predHist));
    resolve(6'd10, 6'd50, 1'b1, 1'b1, 1'b0);
    fetchCheck("R6", 6'd10);
    chk("R6", "agreeing guesses leave chooser", 32'(predUseHist), 32'd1);
    resolve(6'd10, 6'd50, 1'b0, 1'b1, 1'b0);
    fetchCheck("R6", 6'd10);
    chk("R6", "back to address-only", 32'(predUseHist), 32'd0);
    chk("R5", "final follows address-only guess", 32'(predTaken), 32'(predBim));
    resolve(6'd10, 6'd50, 1'b0, 1'b1, 1'b0);
    resolve(6'd10, 6'd50, 1'b0, 1'b1, 1'b0);
    fetchCheck("R6", 6'd10);
    chk("R6", "chooser floor holds", 32'(predUseHist), 32'd0);
    resolve(6'd10, 6'd50, 1'b0, 1'b1, 1'b1);
    fetchCheck("R6", 6'd10);
    chk("R6", "one step from floor stays low", 32'(predUseHist), 32'd0);
  endtask

  task automatic testIdle();
    logic [IW-1:0] histBefore;
    fetchCheck("R8", 6'd10);
    histBefore = fetchHistIdx;
    @(negedge clk);
    resValid = 1'b0; resBimIdx = 6'd10; resHistIdx = 6'd10;
    resBimPred = 1'b0; resHistPred = 1'b1; resTaken = 1'b1;
    repeat (5) @(negedge clk);
    fetchCheck("R8", 6'd10);
    chk("R8", "history unchanged while idle", 32'(fetchHistIdx), 32'(histBefore));
    fetchCheck("R8", 6'd5);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    resValid = 1'b1; resBimIdx = 6'd20; resHistIdx = 6'd60;
    resBimPred = 1'b1; resHistPred = 1'b1; resTaken = 1'b0;
    fetchPc = {{(PC_W-IW-2){1'b0}}, 6'd20, 2'b00};
    #1;
    chk("R9", "fetch sees old value", 32'(predBim), 32'd1);
    @(posedge clk);
    modelTrain(6'd20, 6'd60, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    resValid = 1'b0;
    fetchCheck("R9", 6'd20);
    chk("R9", "update visible next cycle", 32'(predBim), 32'd0);
  endtask

  initial begin
    for (int e = 0; e < N; e++) begin
      mBim[e] = 2'd2; mGsh[e] = 2'd2; mSel[e] = 2'd1;
    end
    mGhr = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSaturation();
    testChooser();
    testIdle();
    testSameCycle();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    nFail++;
    $display("FAIL all watchdog expired: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule